// File: doc/BRIEF.md
# CAN Node Command Dispatcher

This block sits between the frame interfaces of a CAN controller and the I/O of a small node. It decodes the standard identifier of every received frame against a fixed set of six commands and carries out the action. The actions are: sample analog channel 1, report the digital inputs, set digital output 1 or output 2, load a new unit address, or clear both outputs. It then queues a response frame. Each response identifier is the command identifier plus 8. Frames that cannot be served produce an error report on identifier 0x3FF.

Responses wait in a small FIFO until the controller takes them over a valid/ready handshake. Analog samples come from an external converter over a request/acknowledge port. When the tick period is non-zero, the block also samples analog channel 0 on its own and reports the value on 0x3FE. That periodic sample yields to received commands.

Top module: `can_cmd_dispatch`

## Requirements
- R1: After reset, tx_valid_o, adc_req_o and ovf_o are 0, dout_o is 0 and unit_addr_o equals the RESET_ADDR parameter (default 0x10).
- R2: Identifier 0x3F0 (any length) raises adc_req_o with adc_chan_o=1 on the next edge. The request stays up until adc_ack_i. On the acknowledge edge, a frame with id 0x3F8 and dlc 2 is queued. Its byte 0 is adc_data_i[7:0] and its byte 1 is {6'b0, adc_data_i[9:8]}.
- R3: Identifier 0x3F1 (any length) queues id 0x3F9, dlc 1, with byte 0 equal to din_i as sampled on the frame's edge. It is readable the cycle after the frame.
- R4: Identifiers 0x3F2 and 0x3F3 with dlc ≥ 1 load bit 0 of byte 0 into dout_o[0] and dout_o[1] respectively. They are acknowledged on 0x3FA and 0x3FB with dlc 1 and byte 0 = {7'b0, level}.
- R5: Identifier 0x3F4 with dlc ≥ 1 loads byte 0 into unit_addr_o. It is acknowledged on 0x3FC with dlc 1 and byte 0 equal to the new address.
- R6: Identifier 0x3F5 (any length) clears both outputs and queues 0x3FD with dlc 0.
- R7: Any identifier outside 0x3F0..0x3F5 changes no state. It queues 0x3FF, dlc 2, byte 0 = 0x01 and byte 1 = the low 8 identifier bits.
- R8: Identifier 0x3F2, 0x3F3 or 0x3F4 with dlc 0 changes no state. It queues 0x3FF, dlc 2, byte 0 = 0x02 and byte 1 = the low identifier byte.
- R9: Identifier 0x3F0 while a conversion is outstanding starts nothing. It queues 0x3FF, dlc 2, byte 0 = 0x03 and byte 1 = 0xF0.
- R10: Responses leave in queue order. The head frame is held stable while tx_valid_o=1 and tx_ready_i=0, and it is removed on an edge with both high. Unused data bytes are 0.
- R11: The queue holds 4 frames. A response arriving when it is full is dropped, the queued frames are kept, and ovf_o is set and stays set until reset.
- R12: With tick_period_i = P > 0, a channel 0 conversion (adc_chan_o=0) is requested every P cycles. It starts only when no conversion is outstanding and no frame is present. Its result is queued on 0x3FE in the R2 byte format. P = 0 disables the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received frame present this cycle |
| rx_id_i | input | 11 | Received standard identifier |
| rx_dlc_i | input | 4 | Received data length |
| rx_data0_i | input | 8 | Received data byte 0 |
| tx_valid_o | output | 1 | Response frame available |
| tx_ready_i | input | 1 | Controller takes the response frame |
| tx_id_o | output | 11 | Response identifier |
| tx_dlc_o | output | 4 | Response data length |
| tx_data0_o | output | 8 | Response data byte 0 |
| tx_data1_o | output | 8 | Response data byte 1 |
| din_i | input | 8 | Digital inputs |
| dout_o | output | 2 | Digital outputs 1 (bit 0) and 2 (bit 1) |
| unit_addr_o | output | 8 | Current unit address |
| adc_req_o | output | 1 | Conversion request |
| adc_chan_o | output | 1 | Requested channel |
| adc_ack_i | input | 1 | Conversion finished |
| adc_data_i | input | 10 | Conversion result |
| tick_period_i | input | 16 | Periodic sample period in cycles, 0 disables |
| ovf_o | output | 1 | Sticky response queue overflow |

## Verification
Responses that need no conversion, and all error reports, sit at the queue head one edge after the frame's edge. dout_o and unit_addr_o change on that same edge. A conversion request is visible one edge after its frame, and the result frame appears one edge after the acknowledge. The bench drives inputs on falling edges and samples each result at the falling edge that follows the edge where it is due. It never waits a loose number of cycles. For the periodic tick, whose start depends on a free-running counter, the bench waits on adc_req_o with a bounded count and then applies the same one-edge rule to the result.

// File: rtl/can_disp_pkg.sv
package can_disp_pkg;
  localparam int unsigned ID_W = 11;

  localparam logic [ID_W-1:0] ID_CMD_BASE = 11'h3F0;
  localparam logic [ID_W-1:0] ID_RSP_OFS  = 11'h008;
  localparam logic [ID_W-1:0] ID_ANA0     = 11'h3FE;
  localparam logic [ID_W-1:0] ID_ERROR    = 11'h3FF;

  localparam logic [7:0] ERR_BAD_ID = 8'h01;
  localparam logic [7:0] ERR_SHORT  = 8'h02;
  localparam logic [7:0] ERR_BUSY   = 8'h03;

  typedef enum logic [2:0] {
    CMD_ANA1  = 3'd0,
    CMD_DIN   = 3'd1,
    CMD_OUT1  = 3'd2,
    CMD_OUT2  = 3'd3,
    CMD_ADDR  = 3'd4,
    CMD_OFF   = 3'd5,
    CMD_ERROR = 3'd7
  } cmd_e;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [3:0]      dlc;
    logic [7:0]      d0;
    logic [7:0]      d1;
  } frame_t;
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_disp_pkg::*;
(
  input  logic [ID_W-1:0] id_i,
  input  logic [3:0]      dlc_i,
  output cmd_e            cmd_o,
  output logic [7:0]      err_code_o
);
  logic [ID_W-1:0] rel;
  logic            in_set;
  logic            needs_byte;

  assign rel    = id_i - ID_CMD_BASE;
  assign in_set = (id_i >= ID_CMD_BASE) && (rel <= 11'd5);

  always_comb begin
    needs_byte = 1'b0;
    if (in_set)
      needs_byte = (rel[2:0] == 3'd2) || (rel[2:0] == 3'd3) || (rel[2:0] == 3'd4);
  end

  always_comb begin
    cmd_o      = CMD_ERROR;
    err_code_o = 8'h00;
    if (!in_set) begin
      err_code_o = ERR_BAD_ID;
    end else if (needs_byte && dlc_i == 4'd0) begin
      err_code_o = ERR_SHORT;
    end else begin
      cmd_o = cmd_e'(rel[2:0]);
    end
  end
endmodule

// File: rtl/can_resp_fifo.sv
module can_resp_fifo
  import can_disp_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_a_i,
  input  frame_t data_a_i,
  input  logic   push_b_i,
  input  frame_t data_b_i,
  input  logic   pop_i,
  output frame_t head_o,
  output logic   empty_o,
  output logic   drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  frame_t        mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          acc_a, acc_b, do_pop;
  logic [AW:0]   cnt_after_a;

  // pop does not free space in the same cycle
  assign acc_a       = push_a_i && (cnt < DEPTH_C);
  assign cnt_after_a = cnt + (AW+1)'(acc_a);
  assign acc_b       = push_b_i && (cnt_after_a < DEPTH_C);
  assign do_pop      = pop_i && (cnt != '0);
  assign drop_o      = (push_a_i && !acc_a) || (push_b_i && !acc_b);
  assign empty_o     = (cnt == '0);
  assign head_o      = mem[rp];

  always_ff @(posedge clk_i) begin
    if (acc_a) mem[wp] <= data_a_i;
    if (acc_b) mem[wp + AW'(acc_a)] <= data_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + AW'(acc_a) + AW'(acc_b);
      rp  <= rp + AW'(do_pop);
      cnt <= cnt_after_a + (AW+1)'(acc_b) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/can_adc_seq.sv
module can_adc_seq #(
  parameter int unsigned ADC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             chan_i,
  output logic             busy_o,
  output logic             req_o,
  output logic             chan_o,
  input  logic             ack_i,
  output logic             done_o,
  output logic             done_chan_o
);
  logic req_q, chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      chan_q <= 1'b0;
    end else if (!req_q && start_i) begin
      req_q  <= 1'b1;
      chan_q <= chan_i;
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign busy_o      = req_q;
  assign req_o       = req_q;
  assign chan_o      = chan_q;
  assign done_o      = req_q && ack_i;
  assign done_chan_o = chan_q;
endmodule

// File: rtl/can_tick_gen.sv
module can_tick_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             clear_i,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt;
  logic             hit;

  assign hit = (period_i != '0) && (cnt >= period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      pend_o <= 1'b0;
    end else if (period_i == '0) begin
      cnt    <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt <= hit ? '0 : cnt + CNT_W'(1);
      if (hit)          pend_o <= 1'b1;
      else if (clear_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_cmd_dispatch.sv
module can_cmd_dispatch
  import can_disp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned ADC_W      = 10,
  parameter int unsigned TICK_W     = 16,
  parameter logic [7:0]  RESET_ADDR = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [10:0]       rx_id_i,
  input  logic [3:0]        rx_dlc_i,
  input  logic [7:0]        rx_data0_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [10:0]       tx_id_o,
  output logic [3:0]        tx_dlc_o,
  output logic [7:0]        tx_data0_o,
  output logic [7:0]        tx_data1_o,
  input  logic [7:0]        din_i,
  output logic [1:0]        dout_o,
  output logic [7:0]        unit_addr_o,
  output logic              adc_req_o,
  output logic              adc_chan_o,
  input  logic              adc_ack_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  input  logic [TICK_W-1:0] tick_period_i,
  output logic              ovf_o
);
  localparam int unsigned HI_W = ADC_W - 8;

  cmd_e       cmd;
  logic [7:0] err_code;
  logic       adc_busy, adc_done, done_chan;
  logic       tick_pend, start_cmd, start_tick;
  logic       push_b, fifo_empty, fifo_drop;
  frame_t     rsp_b, rsp_a, head;

  can_cmd_decode u_dec (
    .id_i      (rx_id_i),
    .dlc_i     (rx_dlc_i),
    .cmd_o     (cmd),
    .err_code_o(err_code)
  );

  assign start_cmd  = rx_valid_i && (cmd == CMD_ANA1) && !adc_busy;
  assign start_tick = tick_pend && !adc_busy && !rx_valid_i;

  can_adc_seq #(.ADC_W(ADC_W)) u_adc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_cmd || start_tick),
    .chan_i     (start_cmd),
    .busy_o     (adc_busy),
    .req_o      (adc_req_o),
    .chan_o     (adc_chan_o),
    .ack_i      (adc_ack_i),
    .done_o     (adc_done),
    .done_chan_o(done_chan)
  );

  can_tick_gen #(.CNT_W(TICK_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(tick_period_i),
    .clear_i (start_tick),
    .pend_o  (tick_pend)
  );

  // conversion result frame
  always_comb begin
    rsp_a.id  = done_chan ? (ID_CMD_BASE + ID_RSP_OFS) : ID_ANA0;
    rsp_a.dlc = 4'd2;
    rsp_a.d0  = adc_data_i[7:0];
    rsp_a.d1  = 8'(adc_data_i[ADC_W-1 -: HI_W]);
  end

  // command response frame
  always_comb begin
    push_b    = rx_valid_i;
    rsp_b.id  = rx_id_i + ID_RSP_OFS;
    rsp_b.dlc = 4'd1;
    rsp_b.d0  = 8'h00;
    rsp_b.d1  = 8'h00;
    unique case (cmd)
      CMD_ANA1: begin
        push_b    = rx_valid_i && adc_busy;
        rsp_b.id  = ID_ERROR;
        rsp_b.dlc = 4'd2;
        rsp_b.d0  = ERR_BUSY;
        rsp_b.d1  = rx_id_i[7:0];
      end
      CMD_DIN:  rsp_b.d0 = din_i;
      CMD_OUT1, CMD_OUT2: rsp_b.d0 = {7'b0, rx_data0_i[0]};
      CMD_ADDR: rsp_b.d0 = rx_data0_i;
      CMD_OFF:  rsp_b.dlc = 4'd0;
      default: begin
        rsp_b.id  = ID_ERROR;
        rsp_b.dlc = 4'd2;
        rsp_b.d0  = err_code;
        rsp_b.d1  = rx_id_i[7:0];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o      <= 2'b00;
      unit_addr_o <= RESET_ADDR;
      ovf_o       <= 1'b0;
    end else begin
      if (fifo_drop) ovf_o <= 1'b1;
      if (rx_valid_i) begin
        case (cmd)
          CMD_OUT1: dout_o[0]   <= rx_data0_i[0];
          CMD_OUT2: dout_o[1]   <= rx_data0_i[0];
          CMD_ADDR: unit_addr_o <= rx_data0_i;
          CMD_OFF:  dout_o      <= 2'b00;
          default: ;
        endcase
      end
    end
  end

  can_resp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_a_i(adc_done),
    .data_a_i(rsp_a),
    .push_b_i(push_b),
    .data_b_i(rsp_b),
    .pop_i   (tx_ready_i),
    .head_o  (head),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop)
  );

  assign tx_valid_o = !fifo_empty;
  assign tx_id_o    = head.id;
  assign tx_dlc_o   = head.dlc;
  assign tx_data0_o = head.d0;
  assign tx_data1_o = head.d1;
endmodule

// File: rtl/can_disp_chk.sv
module can_disp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic [10:0] rx_id_i,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic [10:0] tx_id_o,
  input logic [3:0]  tx_dlc_o,
  input logic [7:0]  tx_data0_o,
  input logic [7:0]  tx_data1_o,
  input logic [1:0]  dout_o,
  input logic        adc_req_o,
  input logic        adc_chan_o,
  input logic        adc_ack_i,
  input logic        ovf_o
);
  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o &&
      $stable({tx_id_o, tx_dlc_o, tx_data0_o, tx_data1_o}));

  p_adc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !adc_ack_i |=> adc_req_o && $stable(adc_chan_o));

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_id_i == 11'h3F5 |=> dout_o == 2'b00);

  p_tx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_id_o[10:3] == 8'h7F);

  p_err_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_id_o == 11'h3FF |->
      tx_dlc_o == 4'd2 && tx_data0_o >= 8'h01 && tx_data0_o <= 8'h03);
endmodule

bind can_cmd_dispatch can_disp_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_valid_i(rx_valid_i),
  .rx_id_i   (rx_id_i),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .tx_id_o   (tx_id_o),
  .tx_dlc_o  (tx_dlc_o),
  .tx_data0_o(tx_data0_o),
  .tx_data1_o(tx_data1_o),
  .dout_o    (dout_o),
  .adc_req_o (adc_req_o),
  .adc_chan_o(adc_chan_o),
  .adc_ack_i (adc_ack_i),
  .ovf_o     (ovf_o)
);

// File: tb/sim_can_cmd_dispatch.sv
module sim_can_cmd_dispatch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [10:0] rx_id_i = '0;
  logic [3:0]  rx_dlc_i = '0;
  logic [7:0]  rx_data0_i = '0;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic [10:0] tx_id_o;
  logic [3:0]  tx_dlc_o;
  logic [7:0]  tx_data0_o, tx_data1_o;
  logic [7:0]  din_i = '0;
  logic [1:0]  dout_o;
  logic [7:0]  unit_addr_o;
  logic        adc_req_o, adc_chan_o;
  logic        adc_ack_i = 1'b0;
  logic [9:0]  adc_data_i = '0;
  logic [15:0] tick_period_i = '0;
  logic        ovf_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  can_cmd_dispatch u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [10:0] id, logic [3:0] dlc, logic [7:0] d0);
    rx_valid_i = 1'b1; rx_id_i = id; rx_dlc_i = dlc; rx_data0_i = d0;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic pop(string req, logic [10:0] id, logic [3:0] dlc, logic [7:0] d0, logic [7:0] d1);
    check(req, {tx_valid_o, tx_id_o, tx_dlc_o, tx_data0_o, tx_data1_o},
          {1'b1, id, dlc, d0, d1});
    tx_ready_i = 1'b1;
    @(negedge clk_i);
    tx_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 tx_valid", tx_valid_o, 0);
    check("R1 dout", dout_o, 0);
    check("R1 addr", unit_addr_o, 8'h10);
    check("R1 ovf", ovf_o, 0);
    check("R1 adc_req", adc_req_o, 0);
  endtask

  task automatic t_din();
    din_i = 8'h5A;
    send(11'h3F1, 4'd0, 8'h00);
    din_i = 8'h00;
    pop("R3 inputs", 11'h3F9, 4'd1, 8'h5A, 8'h00);
  endtask

  task automatic t_outputs();
    send(11'h3F2, 4'd1, 8'hFF);
    check("R4 out1", dout_o, 2'b01);
    pop("R4 ack1", 11'h3FA, 4'd1, 8'h01, 8'h00);
    send(11'h3F3, 4'd1, 8'h01);
    check("R4 out2", dout_o, 2'b11);
    pop("R4 ack2", 11'h3FB, 4'd1, 8'h01, 8'h00);
    send(11'h3F2, 4'd1, 8'hFE);
    check("R4 out1 low", dout_o, 2'b10);
    pop("R4 ack1 low", 11'h3FA, 4'd1, 8'h00, 8'h00);
  endtask

  task automatic t_addr();
    send(11'h3F4, 4'd1, 8'h2C);
    check("R5 addr", unit_addr_o, 8'h2C);
    pop("R5 ack", 11'h3FC, 4'd1, 8'h2C, 8'h00);
  endtask

  task automatic t_off();
    send(11'h3F5, 4'd3, 8'hAA);
    check("R6 dout", dout_o, 2'b00);
    pop("R6 ack", 11'h3FD, 4'd0, 8'h00, 8'h00);
  endtask

  task automatic t_bad_id();
    send(11'h3F2, 4'd1, 8'h01);
    pop("R4 set", 11'h3FA, 4'd1, 8'h01, 8'h00);
    send(11'h123, 4'd1, 8'h00);
    check("R7 dout kept", dout_o, 2'b01);
    pop("R7 err", 11'h3FF, 4'd2, 8'h01, 8'h23);
    send(11'h3F6, 4'd1, 8'h00);
    check("R7 addr kept", unit_addr_o, 8'h2C);
    pop("R7 err 3F6", 11'h3FF, 4'd2, 8'h01, 8'hF6);
  endtask

  task automatic t_short();
    send(11'h3F4, 4'd0, 8'h55);
    check("R8 addr kept", unit_addr_o, 8'h2C);
    pop("R8 err", 11'h3FF, 4'd2, 8'h02, 8'hF4);
    send(11'h3F3, 4'd0, 8'h01);
    check("R8 dout kept", dout_o, 2'b01);
    pop("R8 err out2", 11'h3FF, 4'd2, 8'h02, 8'hF3);
  endtask

  task automatic t_analog();
    send(11'h3F0, 4'd0, 8'h00);
    check("R2 req", {adc_req_o, adc_chan_o}, 2'b11);
    check("R2 no rsp yet", tx_valid_o, 0);
    send(11'h3F0, 4'd0, 8'h00);
    check("R9 req held", adc_req_o, 1);
    pop("R9 busy err", 11'h3FF, 4'd2, 8'h03, 8'hF0);
    adc_data_i = 10'h3C7; adc_ack_i = 1'b1;
    @(negedge clk_i);
    adc_ack_i = 1'b0; adc_data_i = '0;
    check("R2 req drop", adc_req_o, 0);
    pop("R2 result", 11'h3F8, 4'd2, 8'hC7, 8'h03);
    check("R9 single rsp", tx_valid_o, 0);
  endtask

  task automatic t_order();
    din_i = 8'h11;
    send(11'h3F1, 4'd0, 8'h00);
    send(11'h3F5, 4'd0, 8'h00);
    repeat (3) @(negedge clk_i);
    check("R10 head held", tx_id_o, 11'h3F9);
    pop("R10 first", 11'h3F9, 4'd1, 8'h11, 8'h00);
    pop("R10 second", 11'h3FD, 4'd0, 8'h00, 8'h00);
    check("R10 empty", tx_valid_o, 0);
  endtask

  task automatic t_overflow();
    for (int i = 1; i <= 5; i++) begin
      din_i = 8'(i);
      send(11'h3F1, 4'd0, 8'h00);
    end
    check("R11 ovf", ovf_o, 1);
    for (int i = 1; i <= 4; i++) pop("R11 kept", 11'h3F9, 4'd1, 8'(i), 8'h00);
    check("R11 drop", tx_valid_o, 0);
    repeat (2) @(negedge clk_i);
    check("R11 sticky", ovf_o, 1);
  endtask

  task automatic t_tick();
    int waited;
    waited = 0;
    tick_period_i = 16'd20;
    while (!adc_req_o && waited < 100) begin
      @(negedge clk_i);
      waited++;
    end
    tick_period_i = 16'd0;
    check("R12 req", adc_req_o, 1);
    check("R12 chan0", adc_chan_o, 0);
    adc_data_i = 10'h2A5; adc_ack_i = 1'b1;
    @(negedge clk_i);
    adc_ack_i = 1'b0;
    pop("R12 result", 11'h3FE, 4'd2, 8'hA5, 8'h02);
    repeat (40) @(negedge clk_i);
    check("R12 disabled", adc_req_o, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_din();
    t_outputs();
    t_addr();
    t_off();
    t_bad_id();
    t_short();
    t_analog();
    t_order();
    t_overflow();
    t_tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule